// File: doc/BRIEF.md
# Dual-Modulus Swallow-Counter Feedback Divider

This block divides a fast clock by a programmable integer for the feedback path of a frequency synthesizer. It uses a dual-modulus prescaler that divides by 8 or by 9. A slow main counter counts the prescaler's output pulses. A small swallow counter chooses, at the start of every division cycle, how many of those pulses are stretched to 9 input clocks. The total count per cycle is therefore M·8 + A, where M is the main-count field and A is the swallow field of a 14-bit modulus word.

The modulus word is taken only at the boundary between two division cycles, so a cycle that is in progress always finishes with the length it started with. The two fields are valid only when M is nonzero and M is not smaller than A. While the active word breaks that rule, the block raises an error flag and keeps its output quiet. It also samples the word on every clock, so it recovers as soon as a legal word is presented. Below 56, only some moduli can be reached. Every value from 56 to 16383 can be reached.

Top module: `swallow_fbdiv`

## Requirements
- R1: `rst` is synchronous and active high. While it is high, no pulse is produced, all counters clear, and the present `mod_word` becomes the active word.
- R2: The swallow field A is `mod_word[2:0]` and the main field M is `mod_word[13:3]`. For a legal active word, consecutive output pulses are exactly M·8 + A input clocks apart.
- R3: During each division cycle, the prescaler divides by 9 for its first A output pulses and by 8 for the remaining M−A pulses.
- R4: `div_pulse` is high for exactly one input clock per division cycle. The first pulse after reset is released appears on the (M·8 + A)-th rising edge.
- R5: A new `mod_word` is taken only on the edge that ends a division cycle. A change made in the middle of a cycle does not alter that cycle's length, and it sets the length of the next cycle.
- R6: When the active word has M = 0 or M < A, `cfg_err` is 1 and `div_pulse` stays 0 for as long as such a word is presented.
- R7: While `cfg_err` is 1, the word is sampled on every edge. The first edge that sees a legal word loads it and clears `cfg_err`, and the first pulse follows M·8 + A edges after that loading edge.
- R8: The word with M = A is legal, which gives moduli such as 9 and 63. The largest word (M = 2047, A = 7) gives the maximum modulus of 16383.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| mod_word | input | 14 | Modulus word: [13:3] main count M, [2:0] swallow count A |
| div_pulse | output | 1 | One-clock pulse marking each completed division cycle |
| cfg_err | output | 1 | Active word violates M ≥ 1 and M ≥ A |

## Verification
Two events can land on the same edge: the end of a division cycle and the loading of a new word, which may be legal or illegal. The bench changes the word a few clocks after a pulse and then measures two intervals. The first must keep the old length and the second must take the new one. It also moves from a legal word to an illegal one at a cycle boundary, and there it checks that `cfg_err` appears at that boundary and that no pulse follows. Recovery is judged by counting edges from the moment a legal word is restored to the first pulse.

// File: rtl/swallow_fbdiv_pkg.sv
package swallow_fbdiv_pkg;
  localparam int unsigned PRE_BASE = 8;
  localparam int unsigned WORD_W   = 14;
  localparam int unsigned SWL_W    = $clog2(PRE_BASE);
  localparam int unsigned MAIN_W   = WORD_W - SWL_W;
  localparam int unsigned PCNT_W   = $clog2(PRE_BASE + 1);

  typedef logic [SWL_W-1:0]  swl_t;
  typedef logic [MAIN_W-1:0] main_t;

  function automatic swl_t word_swl(input logic [WORD_W-1:0] w);
    return w[SWL_W-1:0];
  endfunction

  function automatic main_t word_main(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:SWL_W];
  endfunction

  function automatic logic fields_legal(input main_t m, input swl_t a);
    return (m != '0) && (m >= main_t'(a));
  endfunction

  function automatic int unsigned cycle_len(input main_t m, input swl_t a);
    return int'(m) * PRE_BASE + int'(a);
  endfunction
endpackage

// File: rtl/swallow_prescaler.sv
module swallow_prescaler
  import swallow_fbdiv_pkg::*;
(
  input  logic clk,
  input  logic restart,
  input  logic stretch,
  output logic pre_tc
);
  localparam logic [PCNT_W-1:0] LAST_SHORT = PCNT_W'(PRE_BASE - 1);
  localparam logic [PCNT_W-1:0] LAST_LONG  = PCNT_W'(PRE_BASE);

  logic [PCNT_W-1:0] pcnt;
  logic [PCNT_W-1:0] last_val;

  assign last_val = stretch ? LAST_LONG : LAST_SHORT;
  assign pre_tc   = (pcnt == last_val);

  always_ff @(posedge clk) begin
    if (restart || pre_tc) pcnt <= '0;
    else                   pcnt <= pcnt + 1'b1;
  end

  a_r3_presc_bound: assert property (@(posedge clk) disable iff (restart)
    pcnt <= LAST_LONG);
  a_r3_short_wrap: assert property (@(posedge clk) disable iff (restart)
    (!stretch && pcnt == LAST_SHORT) |=> (pcnt == '0));
endmodule

// File: rtl/swallow_word_check.sv
module swallow_word_check
  import swallow_fbdiv_pkg::*;
(
  input  main_t m_val,
  input  swl_t  a_val,
  output logic  bad
);
  assign bad = !fields_legal(m_val, a_val);
endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl
  import swallow_fbdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] mod_word,
  input  logic              pre_tc,
  input  logic              bad,
  output main_t             m_act,
  output swl_t              a_act,
  output logic              stretch,
  output logic              cycle_end,
  output logic              load
);
  main_t mcnt;
  swl_t  acnt;
  main_t m_last;

  assign m_last    = m_act - 1'b1;
  assign stretch   = (acnt != '0);
  assign cycle_end = pre_tc && !bad && (mcnt == m_last);
  assign load      = rst || bad || cycle_end;

  always_ff @(posedge clk) begin
    if (load) begin
      m_act <= word_main(mod_word);
      a_act <= word_swl(mod_word);
      acnt  <= word_swl(mod_word);
      mcnt  <= '0;
    end else if (pre_tc) begin
      mcnt <= mcnt + 1'b1;
      if (acnt != '0) acnt <= acnt - 1'b1;
    end
  end

  a_r2_mcnt_range: assert property (@(posedge clk) disable iff (rst)
    !bad |-> (mcnt < m_act));
  a_r3_swallow_step: assert property (@(posedge clk) disable iff (rst)
    (pre_tc && stretch && !load) |=> (acnt == $past(acnt) - 1'b1));
  a_r3_swallow_hold: assert property (@(posedge clk) disable iff (rst)
    (!pre_tc && !load) |=> $stable(acnt));
  a_r5_word_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(m_act) && $stable(a_act)));
endmodule

// File: rtl/swallow_fbdiv.sv
module swallow_fbdiv
  import swallow_fbdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] mod_word,
  output logic              div_pulse,
  output logic              cfg_err
);
  main_t m_act;
  swl_t  a_act;
  logic  pre_tc;
  logic  stretch;
  logic  cycle_end;
  logic  load;
  logic  bad;
  logic  pulse_q;

  swallow_word_check u_check (
    .m_val (m_act),
    .a_val (a_act),
    .bad   (bad)
  );

  swallow_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mod_word  (mod_word),
    .pre_tc    (pre_tc),
    .bad       (bad),
    .m_act     (m_act),
    .a_act     (a_act),
    .stretch   (stretch),
    .cycle_end (cycle_end),
    .load      (load)
  );

  swallow_prescaler u_pre (
    .clk     (clk),
    .restart (rst || bad),
    .stretch (stretch),
    .pre_tc  (pre_tc)
  );

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= cycle_end;
  end

  assign div_pulse = pulse_q;
  assign cfg_err   = bad;

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);
  a_r6_err_quiet: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> !div_pulse);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> !div_pulse);
endmodule

// File: tb/swallow_fbdiv_test.sv
module swallow_fbdiv_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCH = 40000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [13:0] mod_word = 14'd0;
  logic div_pulse;
  logic cfg_err;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swallow_fbdiv uut (
    .clk       (clk),
    .rst       (rst),
    .mod_word  (mod_word),
    .div_pulse (div_pulse),
    .cfg_err   (cfg_err)
  );

  function automatic int expect_len(int m, int a);
    return a * 9 + (m - a) * 8;
  endfunction

  function automatic bit is_ok(int m, int a);
    return !(m == 0 || a > m);
  endfunction

  function automatic logic [13:0] mk(int m, int a);
    return {11'(m), 3'(a)};
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // negedges until a pulse is seen; -1 on watchdog
  task automatic edges_to_pulse(output int n);
    n = 0;
    for (int i = 0; i < WATCH; i++) begin
      @(negedge clk);
      n++;
      if (div_pulse) return;
    end
    n = -1;
  endtask

  task automatic measure(string req, int m, int a);
    int n;
    edges_to_pulse(n);
    check(req, n, expect_len(m, a));
    @(negedge clk);
    check("R4 width", int'(div_pulse), 0);
    edges_to_pulse(n);
    check(req, n + 1, expect_len(m, a));
  endtask

  task automatic apply_and_measure(string req, int m, int a);
    int n;
    mod_word = mk(m, a);
    edges_to_pulse(n);
    if (n < 0) check("watchdog", n, 0);
    measure(req, m, a);
  endtask

  initial begin
    int n;
    int m;
    int a;
    int hits;
    mod_word = mk(5, 3);
    repeat (3) @(negedge clk);
    check("R1 no pulse in reset", int'(div_pulse), 0);
    check("R1 err clear", int'(cfg_err), 0);
    rst = 1'b0;
    edges_to_pulse(n);
    check("R4 first pulse", n, expect_len(5, 3));
    @(negedge clk);
    check("R4 width", int'(div_pulse), 0);
    edges_to_pulse(n);
    check("R2 interval 5,3", n + 1, expect_len(5, 3));

    apply_and_measure("R2 min 1,0", 1, 0);
    apply_and_measure("R8 1,1", 1, 1);
    apply_and_measure("R8 7,7", 7, 7);
    apply_and_measure("R3 6,0", 6, 0);
    apply_and_measure("R3 7,1", 7, 1);
    apply_and_measure("R8 max", 2047, 7);

    void'($urandom(32'h5a17));
    for (int k = 0; k < 30; k++) begin
      a = $urandom_range(7, 0);
      m = $urandom_range(150, a == 0 ? 1 : a);
      apply_and_measure("R2 random", m, a);
    end

    // R5: change mid-cycle
    mod_word = mk(10, 2);
    edges_to_pulse(n);
    repeat (4) @(negedge clk);
    mod_word = mk(3, 1);
    edges_to_pulse(n);
    check("R5 cycle kept", n + 4, expect_len(10, 2));
    edges_to_pulse(n);
    check("R5 next cycle", n, expect_len(3, 1));

    // R6: illegal M<A loaded at boundary
    mod_word = mk(6, 7);
    edges_to_pulse(n);
    check("R6 err at boundary", int'(cfg_err), int'(!is_ok(6, 7)));
    hits = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (div_pulse) hits++;
    end
    check("R6 quiet M<A", hits, 0);
    check("R6 err held", int'(cfg_err), 1);
    mod_word = mk(0, 0);
    @(negedge clk);
    check("R6 err M=0", int'(cfg_err), int'(!is_ok(0, 0)));
    hits = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (div_pulse) hits++;
    end
    check("R6 quiet M=0", hits, 0);

    // R7: recovery
    mod_word = mk(4, 4);
    @(negedge clk);
    check("R7 err cleared", int'(cfg_err), 0);
    edges_to_pulse(n);
    check("R7 first pulse", n + 1, expect_len(4, 4) + 1);
    edges_to_pulse(n);
    check("R7 interval", n, expect_len(4, 4));

    // R1: reset mid-cycle
    mod_word = mk(2, 0);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    hits = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (div_pulse) hits++;
    end
    check("R1 reset quiet", hits, 0);
    rst = 1'b0;
    edges_to_pulse(n);
    check("R1 restart length", n, expect_len(2, 0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule